// File: doc/BRIEF.md
# Lane-Partitioned Integer ALU Stage

This block is one pipeline stage of a 32-bit integer arithmetic unit whose datapath can be split into independent lanes. A mode input chooses whether the two operands are one 32-bit word, a pair of 16-bit halves or four bytes. An opcode chooses add, subtract, unsigned minimum, unsigned maximum or one of three bitwise operations. Every lane computes on its own, so in byte mode four separate pixel-sized operations finish in a single clock.

The arithmetic is built from one adder made of byte-wide segments. The carry between two neighbouring segments is passed on only when both segments belong to the same lane. Otherwise the next segment starts fresh with the lane's own carry-in. The carry out of each lane also drives the unsigned comparison for minimum and maximum, and the optional clamping of add and subtract.

Operands enter with a valid strobe. The result leaves from a register one clock later, together with a delayed copy of the strobe.

Top module: `simd_part_alu`

## Requirements
- R1: The result and `out_valid` are registered, with one cycle of latency: `out_valid` equals the `in_valid` of the previous clock. A synchronous reset clears both `out_valid` and `result` to zero.
- R2: While `in_valid` is low, `result` keeps its previous value, whatever the operands, mode and opcode are.
- R3: The mode values are 2'b00 for one 32-bit lane, 2'b01 for two 16-bit lanes (bits 15:0 and 31:16) and 2'b10 for four 8-bit lanes (bits 8k+7:8k). The value 2'b11 behaves exactly like 2'b00.
- R4: Opcode 3'b000 adds the two operands lane by lane, modulo the lane width. No carry passes into the next lane.
- R5: Opcode 3'b001 subtracts `opb` from `opa` lane by lane, modulo the lane width. No borrow passes into the next lane.
- R6: Opcode 3'b010 gives the unsigned minimum and opcode 3'b011 the unsigned maximum of each lane. Each lane is compared independently.
- R7: Opcodes 3'b100, 3'b101 and 3'b110 give bitwise AND, OR and XOR. The result does not depend on the mode.
- R8: When `sat` is high, an unsigned overflow in an add sets that lane to all ones, and an unsigned underflow in a subtract sets that lane to zero. For all other opcodes, `sat` has no effect.
- R9: The unused opcode 3'b111 gives an all-zero result.
- R10: A new operation is accepted on every clock. In byte mode, back-to-back operations each return four independent byte results, in order, one clock after they were issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| mode | input | 2 | Lane partition select |
| op | input | 3 | Operation select |
| sat | input | 1 | Clamp unsigned add/subtract per lane |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand (subtrahend) |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Registered result |

## Verification
On every clock, the assertions check the valid pipeline and the holding of the result while idle. In byte mode they also check lane-local bounds: a clamped add never drops below its first operand, a clamped subtract never rises above it, and minimum and maximum stay bounded by both inputs of each lane. They also check the XOR result and the zero output of the reserved opcode. The exact values at lane boundaries need the bench's scenarios and its per-cycle reference model. These include wraparound that must not leak into a neighbour, the 16-bit split, mode 2'b11 acting as 32-bit, and `sat` being ignored for bitwise operations.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  localparam int unsigned SEG_W_DEF   = 8;
  localparam int unsigned NUM_SEG_DEF = 4;

  typedef enum logic [1:0] {
    MODE_W32 = 2'b00,
    MODE_W16 = 2'b01,
    MODE_W8  = 2'b10,
    MODE_RSV = 2'b11
  } lane_mode_e;

  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_MIN = 3'b010,
    OP_MAX = 3'b011,
    OP_AND = 3'b100,
    OP_OR  = 3'b101,
    OP_XOR = 3'b110,
    OP_RSV = 3'b111
  } alu_op_e;

endpackage

// File: rtl/simd_join_map.sv
module simd_join_map
  import simd_alu_pkg::*;
#(
  parameter int unsigned NUM_SEG = NUM_SEG_DEF
) (
  input  lane_mode_e         mode,
  output logic [NUM_SEG-2:0] join_o
);

  // join_o[g] = 1 when segments g and g+1 sit inside one lane
  always_comb begin
    for (int g = 0; g < NUM_SEG - 1; g++) begin
      unique case (mode)
        MODE_W16: join_o[g] = ((g % 2) == 0);
        MODE_W8:  join_o[g] = 1'b0;
        default:  join_o[g] = 1'b1;   // full word, including the spare code
      endcase
    end
  end

endmodule

// File: rtl/simd_seg_adder.sv
module simd_seg_adder
  import simd_alu_pkg::*;
#(
  parameter int unsigned SEG_W   = SEG_W_DEF,
  parameter int unsigned NUM_SEG = NUM_SEG_DEF,
  localparam int unsigned DATA_W = SEG_W * NUM_SEG
) (
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  b,
  input  logic               invert,
  input  logic [NUM_SEG-2:0] join_i,
  output logic [DATA_W-1:0]  sum,
  output logic [NUM_SEG-1:0] seg_cout
);

  logic [NUM_SEG-1:0] seg_cin;

  assign seg_cin[0] = invert;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic [SEG_W-1:0] b_eff;
    logic [SEG_W:0]   wide;

    assign b_eff = b[g*SEG_W +: SEG_W] ^ {SEG_W{invert}};
    assign wide  = {1'b0, a[g*SEG_W +: SEG_W]} + {1'b0, b_eff} + {{SEG_W{1'b0}}, seg_cin[g]};
    assign sum[g*SEG_W +: SEG_W] = wide[SEG_W-1:0];
    assign seg_cout[g] = wide[SEG_W];

    if (g < NUM_SEG - 1) begin : g_link
      // carry crosses only when the next segment belongs to the same lane
      assign seg_cin[g+1] = join_i[g] ? wide[SEG_W] : invert;
    end
  end

endmodule

// File: rtl/simd_lane_resolve.sv
module simd_lane_resolve
  import simd_alu_pkg::*;
#(
  parameter int unsigned SEG_W   = SEG_W_DEF,
  parameter int unsigned NUM_SEG = NUM_SEG_DEF,
  localparam int unsigned DATA_W = SEG_W * NUM_SEG
) (
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  b,
  input  logic [DATA_W-1:0]  sum,
  input  logic [NUM_SEG-1:0] seg_cout,
  input  logic [NUM_SEG-2:0] join_i,
  input  alu_op_e            op,
  input  logic               sat,
  output logic [DATA_W-1:0]  y
);

  // carry out of the top segment of the lane that holds each segment
  logic [NUM_SEG-1:0] lane_c;

  assign lane_c[NUM_SEG-1] = seg_cout[NUM_SEG-1];

  for (genvar g = 0; g < NUM_SEG - 1; g++) begin : g_lc
    assign lane_c[g] = join_i[g] ? lane_c[g+1] : seg_cout[g];
  end

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_sel
    logic [SEG_W-1:0] sa, sb, ss, so;

    assign sa = a[g*SEG_W +: SEG_W];
    assign sb = b[g*SEG_W +: SEG_W];
    assign ss = sum[g*SEG_W +: SEG_W];

    always_comb begin
      unique case (op)
        OP_ADD:  so = (sat && lane_c[g])  ? {SEG_W{1'b1}} : ss;
        OP_SUB:  so = (sat && !lane_c[g]) ? {SEG_W{1'b0}} : ss;
        OP_MIN:  so = lane_c[g] ? sb : sa;   // no borrow: a >= b
        OP_MAX:  so = lane_c[g] ? sa : sb;
        OP_AND:  so = sa & sb;
        OP_OR:   so = sa | sb;
        OP_XOR:  so = sa ^ sb;
        default: so = {SEG_W{1'b0}};
      endcase
    end

    assign y[g*SEG_W +: SEG_W] = so;
  end

endmodule

// File: rtl/simd_part_alu.sv
module simd_part_alu
  import simd_alu_pkg::*;
#(
  parameter int unsigned SEG_W   = SEG_W_DEF,
  parameter int unsigned NUM_SEG = NUM_SEG_DEF,
  localparam int unsigned DATA_W = SEG_W * NUM_SEG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        mode,
  input  logic [2:0]        op,
  input  logic              sat,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);

  lane_mode_e          mode_e;
  alu_op_e             op_e;
  logic                invert;
  logic [NUM_SEG-2:0]  join_w;
  logic [DATA_W-1:0]   sum_w;
  logic [NUM_SEG-1:0]  cout_w;
  logic [DATA_W-1:0]   y_w;

  assign mode_e = lane_mode_e'(mode);
  assign op_e   = alu_op_e'(op);
  assign invert = (op_e == OP_SUB) || (op_e == OP_MIN) || (op_e == OP_MAX);

  simd_join_map #(.NUM_SEG(NUM_SEG)) u_join (
    .mode   (mode_e),
    .join_o (join_w)
  );

  simd_seg_adder #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_add (
    .a        (opa),
    .b        (opb),
    .invert   (invert),
    .join_i   (join_w),
    .sum      (sum_w),
    .seg_cout (cout_w)
  );

  simd_lane_resolve #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_res (
    .a        (opa),
    .b        (opb),
    .sum      (sum_w),
    .seg_cout (cout_w),
    .join_i   (join_w),
    .op       (op_e),
    .sat      (sat),
    .y        (y_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= y_w;
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);                                            // R1
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);                                          // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));                                     // R2
  AST_XOR_WORD: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_XOR) |=> result == ($past(opa) ^ $past(opb))); // R7
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_RSV) |=> result == '0);                       // R9

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_chk
    AST_SAT_ADD_FLOOR: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode == MODE_W8 && op == OP_ADD && sat)
      |=> result[g*SEG_W +: SEG_W] >= $past(opa[g*SEG_W +: SEG_W]));   // R8
    AST_SAT_SUB_CEIL: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode == MODE_W8 && op == OP_SUB && sat)
      |=> result[g*SEG_W +: SEG_W] <= $past(opa[g*SEG_W +: SEG_W]));   // R8
    AST_MIN_BOUND: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode == MODE_W8 && op == OP_MIN)
      |=> (result[g*SEG_W +: SEG_W] <= $past(opa[g*SEG_W +: SEG_W])) &&
          (result[g*SEG_W +: SEG_W] <= $past(opb[g*SEG_W +: SEG_W]))); // R6
    AST_MAX_BOUND: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode == MODE_W8 && op == OP_MAX)
      |=> (result[g*SEG_W +: SEG_W] >= $past(opa[g*SEG_W +: SEG_W])) &&
          (result[g*SEG_W +: SEG_W] >= $past(opb[g*SEG_W +: SEG_W]))); // R6
  end

endmodule

// File: tb/simd_part_alu_tb_top.sv
`timescale 1ns/1ps
module simd_part_alu_tb_top;

  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [2:0]  op = 3'b000;
  logic        sat = 1'b0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic        out_valid;
  logic [31:0] result;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  simd_part_alu dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .op(op),
    .sat(sat), .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
  );

  function automatic logic [31:0] ref_op(logic [1:0] m, logic [2:0] o, logic s,
                                         logic [31:0] a, logic [31:0] b);
    int w, n;
    longint unsigned mx, x, y, z;
    logic [31:0] r;
    w  = (m == 2'b01) ? 16 : (m == 2'b10) ? 8 : 32;
    n  = 32 / w;
    mx = (64'd1 << w) - 1;
    r  = '0;
    for (int k = 0; k < n; k++) begin
      x = (longint'(a) >> (k*w)) & mx;
      y = (longint'(b) >> (k*w)) & mx;
      case (o)
        3'd0: begin z = x + y; if (s && z > mx) z = mx; end
        3'd1: begin
          if (x < y) z = s ? 0 : (x + mx + 1 - y);
          else       z = x - y;
        end
        3'd2: z = (x < y) ? x : y;
        3'd3: z = (x > y) ? x : y;
        3'd4: z = x & y;
        3'd5: z = x | y;
        3'd6: z = x ^ y;
        default: z = 0;
      endcase
      r = r | (32'(z & mx) << (k*w));
    end
    return r;
  endfunction

  function automatic string tag_of(logic [2:0] o, logic s);
    case (o)
      3'd0: return s ? "R8" : "R4";
      3'd1: return s ? "R8" : "R5";
      3'd2, 3'd3: return "R6";
      3'd7: return "R9";
      default: return "R7";
    endcase
  endfunction

  // behavioural reference, updated on the same edge as the design
  logic        m_valid = 1'b0;
  logic [31:0] m_res   = '0;
  string       m_tag   = "R1";

  always @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_res   <= '0;
      m_tag   <= "R1";
    end else begin
      m_valid <= in_valid;
      if (in_valid) begin
        m_res <= ref_op(mode, op, sat, opa, opb);
        m_tag <= tag_of(op, sat);
      end else begin
        m_tag <= "R2";
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (out_valid !== m_valid || result !== m_res) begin
        n_fail++;
        $display("FAIL %s/R1 model: got v=%0b %h exp v=%0b %h", m_tag, out_valid, result, m_valid, m_res);
      end
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic issue(logic [1:0] m, logic [2:0] o, logic s, logic [31:0] a, logic [31:0] b);
    in_valid = 1'b1; mode = m; op = o; sat = s; opa = a; opb = b;
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset result", result, 32'd0);

    // lane isolation of carries
    issue(2'b10, 3'd0, 1'b0, 32'h01FF80FF, 32'h01018001); check("R4 W8 add", result, 32'h02000000);
    issue(2'b01, 3'd0, 1'b0, 32'h01FF80FF, 32'h01018001); check("R3 W16 add", result, 32'h03000100);
    issue(2'b00, 3'd0, 1'b0, 32'h01FF80FF, 32'h01018001); check("R3 W32 add", result, 32'h03010100);
    issue(2'b11, 3'd0, 1'b0, 32'h01FF80FF, 32'h01018001); check("R3 mode 11", result, 32'h03010100);

    // borrows and clamping
    issue(2'b10, 3'd1, 1'b0, 32'h00100580, 32'h01010680); check("R5 W8 sub", result, 32'hFF0FFF00);
    issue(2'b10, 3'd1, 1'b1, 32'h00100580, 32'h01010680); check("R8 sat sub", result, 32'h000F0000);
    issue(2'b10, 3'd0, 1'b1, 32'hF010FF7F, 32'h20100101); check("R8 sat add", result, 32'hFF20FF80);
    issue(2'b10, 3'd4, 1'b1, 32'hF0F0F0F0, 32'hFF00FF00); check("R8 sat on AND", result, 32'hF000F000);

    // unsigned per-lane compare
    issue(2'b10, 3'd2, 1'b0, 32'h108005FF, 32'h207F0500); check("R6 min", result, 32'h107F0500);
    issue(2'b10, 3'd3, 1'b0, 32'h108005FF, 32'h207F0500); check("R6 max", result, 32'h208005FF);

    // bitwise, reserved opcode
    issue(2'b01, 3'd5, 1'b0, 32'h12340000, 32'h0000ABCD); check("R7 or", result, 32'h1234ABCD);
    issue(2'b10, 3'd6, 1'b0, 32'hFFFF0000, 32'h0F0F0F0F); check("R7 xor", result, 32'hF0F00F0F);
    issue(2'b00, 3'd7, 1'b0, 32'hFFFFFFFF, 32'h12345678); check("R9 reserved", result, 32'h00000000);

    // hold while idle
    issue(2'b10, 3'd0, 1'b0, 32'h01020304, 32'h10101010); check("R4 pre-hold", result, 32'h11121314);
    in_valid = 1'b0; op = 3'd7; opa = 32'hDEADBEEF;
    @(negedge clk); check("R2 hold 1", result, 32'h11121314);
    check("R1 valid low", {31'd0, out_valid}, 32'd0);
    mode = 2'b00; op = 3'd0;
    @(negedge clk); check("R2 hold 2", result, 32'h11121314);

    // back-to-back byte operations
    issue(2'b10, 3'd0, 1'b0, 32'hFFFFFFFF, 32'h01010101); check("R10 burst 1", result, 32'h00000000);
    issue(2'b10, 3'd1, 1'b0, 32'h00000000, 32'h01010101); check("R10 burst 2", result, 32'hFFFFFFFF);
    issue(2'b10, 3'd3, 1'b0, 32'h01FF7F80, 32'h80017F81); check("R10 burst 3", result, 32'h80FF7F81);
    idle();

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      in_valid = ($urandom_range(0, 3) != 0);
      mode = 2'($urandom_range(0, 3));
      op   = 3'($urandom_range(0, 7));
      sat  = 1'($urandom_range(0, 1));
      opa  = $urandom;
      opb  = ($urandom_range(0, 3) == 0) ? opa : $urandom;
      @(negedge clk);
    end
    idle();
    idle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule